// File: doc/BRIEF.md
# SD Host Command Issue and Line-Inhibit Unit

This unit sits between the host's register interface and the command-line serializer of an SD host controller. Software first writes a 32-bit argument, then the 16-bit command word. Writing the upper byte of the command word starts the command. The unit decodes the response kind and the check flags from that word. It raises a one-cycle start strobe toward the serializer, carrying the decoded fields and the argument.

Two busy flags tell software when it may issue. The command flag covers the CMD line. The data flag covers the DAT lines. The data flag is taken only by commands that move data or that expect a response followed by busy signalling. Each flag is released by the serializer event that matches the command that took it. When a command finishes, the unit stores the response. A long response is stored right-justified with its CRC byte dropped.

A three-bit software reset register aborts activity on the command side, the data side, or both. Its bits clear themselves after a fixed number of cycles.

Top module: `sdcmd_issue`

## Requirements
- R1: After reset, both inhibit flags, all strobes and pulses, the reset bits, both abort outputs and all 128 response bits are 0.
- R2: A cycle with `cmd_we` and `cmd_be[1]` set launches a command, and `start` pulses in the next cycle. The command word is {`cmd_wdata[15:8]`, low byte}. The low byte comes from `cmd_wdata[7:0]` when `cmd_be[0]` is set, and otherwise from the last low byte written alone. The strobe carries the following fields:
  - index = bits 13:8
  - abort when bits 7:6 = 3
  - data = bit 5
  - index check = bit 4
  - CRC check = bit 3
  - response kind = bits 1:0 (0 none, 1 long 136-bit, 2 short 48-bit, 3 short with busy)
  - the argument from the most recent earlier `arg_we`
  A write with only `cmd_be[0]` set does not launch.
- R3: A launch is ignored while `inhibit_cmd` is set. A launch is also ignored while `inhibit_dat` is set if the command has bit 5 set or response kind 3. Any other command is accepted while only `inhibit_dat` is set.
- R4: `inhibit_cmd` rises in the same cycle as `start`. It falls in the cycle after `ser_done` or `ser_err` arrives while it is set.
- R5: `inhibit_dat` rises with `start` when the command has bit 5 set or response kind 3.
- R6: `ser_done` while `inhibit_cmd` is set gives a one-cycle `cmd_complete` in the next cycle. `ser_err` clears the flag without a pulse. Either input is ignored while `inhibit_cmd` is clear.
- R7: A data flag taken by a kind-3 command clears only on `ser_busy_end`. A data flag taken by a data command clears only on `ser_xfer_done`. Each such release gives a one-cycle `xfer_complete` in the next cycle.
- R8: On completion of a kind-2 or kind-3 command, response bits 31:0 take `ser_resp[31:0]` and bits 127:32 are left unchanged. A kind-0 completion changes no response bit.
- R9: On completion of a kind-1 command, the response becomes {8'h00, `ser_resp[127:8]`}.
- R10: A write of nonzero bits to the reset register ORs them into `srst_bits` for RST_CYCLES cycles (default 4), after which they self-clear. While a write is present or any bit is set, launches and all serializer inputs are ignored.
- R11: Bit 0 or bit 1 clears `inhibit_cmd` and drops a launch in the same cycle. Bit 0 or bit 2 clears `inhibit_dat`. Bit 0 also zeroes the response. `abort_cmd` follows bit0|bit1 and `abort_dat` follows bit0|bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_we | input | 1 | Argument write |
| arg_wdata | input | ARG_W | Argument value |
| cmd_we | input | 1 | Command word write |
| cmd_be | input | 2 | Byte enables of the command write; bit 1 launches |
| cmd_wdata | input | 16 | Command word value |
| srst_we | input | 1 | Software reset register write |
| srst_wdata | input | 3 | Reset bits: 0 all, 1 command side, 2 data side |
| ser_done | input | 1 | Serializer: command phase finished |
| ser_err | input | 1 | Serializer: timeout or error on command phase |
| ser_busy_end | input | 1 | Serializer: busy signalling ended |
| ser_xfer_done | input | 1 | Serializer: data transfer finished |
| ser_resp | input | 128 | Raw response content from the serializer |
| start | output | 1 | One-cycle start strobe |
| start_word | output | 16 | Command word issued |
| start_index | output | 6 | Command index |
| start_rsp | output | 2 | Response kind |
| start_abort | output | 1 | Abort-type command |
| start_data | output | 1 | Data-present flag |
| start_idx_chk | output | 1 | Index check enable |
| start_crc_chk | output | 1 | CRC check enable |
| start_dat_line | output | 1 | Command uses the data lines (data or busy) |
| start_arg | output | ARG_W | Argument issued |
| inhibit_cmd | output | 1 | Command-line inhibit flag |
| inhibit_dat | output | 1 | Data-line inhibit flag |
| cmd_complete | output | 1 | Command-complete pulse |
| xfer_complete | output | 1 | Transfer-complete pulse |
| resp_words | output | 128 | Four stored response words, word 0 in bits 31:0 |
| srst_bits | output | 3 | Reset register read-back |
| abort_cmd | output | 1 | Command-side reset in progress |
| abort_dat | output | 1 | Data-side reset in progress |

## Verification
The hardest state to reach is a data flag held by a busy-type command while other traffic goes on. In that state a plain command must be accepted, a data command must be refused, and a stray transfer-done must be ignored. The stimulus issues a kind-3 command and completes its command phase, then deliberately withholds `ser_busy_end`. With the flag still held, it issues a short command, an illegal data command, and a misdirected `ser_xfer_done` before releasing busy. A second hard case is the collision of a launch or a serializer pulse with a reset write in the same cycle. The stimulus drives these coincidences on the same negative edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_LONG = 2'd1,
    RSP_SHRT = 2'd2,
    RSP_BUSY = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic [15:0] word;
    logic [5:0]  index;
    logic        abort;
    logic        data;
    logic        idx_chk;
    logic        crc_chk;
    rsp_kind_e   rsp;
    logic        dat_line;
  } cmd_fields_t;

  function automatic cmd_fields_t decode_cmd(input logic [15:0] w);
    cmd_fields_t f;
    f.word     = w;
    f.index    = w[13:8];
    f.abort    = (w[7:6] == 2'd3);
    f.data     = w[5];
    f.idx_chk  = w[4];
    f.crc_chk  = w[3];
    f.rsp      = rsp_kind_e'(w[1:0]);
    f.dat_line = w[5] || (w[1:0] == 2'd3);
    return f;
  endfunction

endpackage

// File: rtl/sdcmd_swreset.sv
module sdcmd_swreset #(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [2:0] wdata,
  output logic [2:0] bits,
  output logic       hit,
  output logic       active,
  output logic       clr_cmd,
  output logic       clr_dat,
  output logic       clr_all
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign hit     = wr && (wdata != 3'b000);
  assign active  = (bits != 3'b000);
  assign clr_all = hit && wdata[0];
  assign clr_cmd = hit && (wdata[0] || wdata[1]);
  assign clr_dat = hit && (wdata[0] || wdata[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= 3'b000;
      cnt  <= '0;
    end else if (hit) begin
      bits <= bits | wdata;
      cnt  <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        bits <= 3'b000;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: written bits are visible in the following cycle
  a_r10_bits_set: assert property (@(posedge clk) disable iff (rst)
    hit |=> ((bits & $past(wdata)) == $past(wdata)));

endmodule

// File: rtl/sdcmd_issue_ctl.sv
module sdcmd_issue_ctl
  import sdcmd_pkg::*;
#(
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch_req,
  input  logic [15:0]      launch_word,
  input  logic [ARG_W-1:0] arg_q,
  input  logic             rst_hit,
  input  logic             rst_active,
  input  logic             clr_cmd,
  input  logic             clr_dat,
  input  logic             ser_done,
  input  logic             ser_err,
  input  logic             busy_end,
  input  logic             xfer_done,
  output logic             start,
  output cmd_fields_t      start_f,
  output logic [ARG_W-1:0] start_arg,
  output logic             inh_cmd,
  output logic             inh_dat,
  output logic             cmd_cmpl,
  output logic             xfer_cmpl,
  output logic             done_ok,
  output rsp_kind_e        pend_rsp
);
  cmd_fields_t f;
  logic quiet, launch_ok, err_ok, bend_ok, xdone_ok, by_busy;

  assign f         = decode_cmd(launch_word);
  assign quiet     = !rst_hit && !rst_active;
  assign launch_ok = launch_req && quiet && !inh_cmd && !(f.dat_line && inh_dat);
  assign done_ok   = ser_done && inh_cmd && quiet;
  assign err_ok    = ser_err && !ser_done && inh_cmd && quiet;
  assign bend_ok   = busy_end && inh_dat && by_busy && quiet;
  assign xdone_ok  = xfer_done && inh_dat && !by_busy && quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      start     <= 1'b0;
      start_f   <= '0;
      start_arg <= '0;
      pend_rsp  <= RSP_NONE;
      inh_cmd   <= 1'b0;
      inh_dat   <= 1'b0;
      by_busy   <= 1'b0;
      cmd_cmpl  <= 1'b0;
      xfer_cmpl <= 1'b0;
    end else begin
      start     <= launch_ok;
      cmd_cmpl  <= done_ok;
      xfer_cmpl <= bend_ok || xdone_ok;
      if (launch_ok) begin
        start_f   <= f;
        start_arg <= arg_q;
        pend_rsp  <= f.rsp;
      end
      if (clr_cmd)                       inh_cmd <= 1'b0;
      else if (launch_ok)                inh_cmd <= 1'b1;
      else if (done_ok || err_ok)        inh_cmd <= 1'b0;
      if (clr_dat)                       inh_dat <= 1'b0;
      else if (launch_ok && f.dat_line) begin
        inh_dat <= 1'b1;
        by_busy <= (f.rsp == RSP_BUSY);
      end else if (bend_ok || xdone_ok)  inh_dat <= 1'b0;
    end
  end

  // R4: the strobe never appears without the command flag
  a_r4_start_sets_inhibit: assert property (@(posedge clk) disable iff (rst)
    start |-> inh_cmd);
  // R3: no launch was taken while the command flag was held
  a_r3_no_launch_inhibited: assert property (@(posedge clk) disable iff (rst)
    start |-> !$past(inh_cmd));
  // R5: commands using the data lines hold the data flag
  a_r5_dat_taken: assert property (@(posedge clk) disable iff (rst)
    (start && start_f.dat_line) |-> inh_dat);
  // R6: completion pulse coincides with a released command flag
  a_r6_cmpl_released: assert property (@(posedge clk) disable iff (rst)
    cmd_cmpl |-> !inh_cmd);
  // R7: transfer pulse coincides with a released data flag
  a_r7_xfer_released: assert property (@(posedge clk) disable iff (rst)
    xfer_cmpl |-> !inh_dat);
  // R11: command-side reset clears the flag and drops any launch
  a_r11_cmd_abort: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (!inh_cmd && !start));

endmodule

// File: rtl/sdcmd_resp_store.sv
module sdcmd_resp_store
  import sdcmd_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                capture,
  input  rsp_kind_e           kind,
  input  logic [WORDS*32-1:0] raw,
  output logic [WORDS*32-1:0] words
);
  localparam int TOT = WORDS * 32;

  logic [TOT-1:0] shifted;
  logic           is_long, is_short;

  assign shifted  = {8'h00, raw[TOT-1:8]};
  assign is_long  = capture && (kind == RSP_LONG);
  assign is_short = capture && ((kind == RSP_SHRT) || (kind == RSP_BUSY));

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || clear)             words[i*32 +: 32] <= '0;
      else if (is_long)             words[i*32 +: 32] <= shifted[i*32 +: 32];
      else if (is_short && i == 0)  words[i*32 +: 32] <= raw[31:0];
    end
  end

  // R9: top byte of a stored long response is always empty
  a_r9_crc_dropped: assert property (@(posedge clk) disable iff (rst)
    (is_long && !clear) |=> (words[TOT-1:TOT-8] == 8'h00));
  // R8: a short response leaves the upper words alone
  a_r8_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (is_short && !clear) |=> $stable(words[TOT-1:32]));

endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
  import sdcmd_pkg::*;
#(
  parameter int ARG_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arg_we,
  input  logic [ARG_W-1:0] arg_wdata,
  input  logic             cmd_we,
  input  logic [1:0]       cmd_be,
  input  logic [15:0]      cmd_wdata,
  input  logic             srst_we,
  input  logic [2:0]       srst_wdata,
  input  logic             ser_done,
  input  logic             ser_err,
  input  logic             ser_busy_end,
  input  logic             ser_xfer_done,
  input  logic [127:0]     ser_resp,
  output logic             start,
  output logic [15:0]      start_word,
  output logic [5:0]       start_index,
  output logic [1:0]       start_rsp,
  output logic             start_abort,
  output logic             start_data,
  output logic             start_idx_chk,
  output logic             start_crc_chk,
  output logic             start_dat_line,
  output logic [ARG_W-1:0] start_arg,
  output logic             inhibit_cmd,
  output logic             inhibit_dat,
  output logic             cmd_complete,
  output logic             xfer_complete,
  output logic [127:0]     resp_words,
  output logic [2:0]       srst_bits,
  output logic             abort_cmd,
  output logic             abort_dat
);
  localparam int RESP_WORDS = 4;

  logic [ARG_W-1:0] arg_q;
  logic [7:0]       cmd_lo;
  logic [15:0]      launch_word;
  logic             launch_req;
  logic             rst_hit, rst_active, clr_cmd, clr_dat, clr_all, done_ok;
  cmd_fields_t      sf;
  rsp_kind_e        pend_rsp;

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q  <= '0;
      cmd_lo <= '0;
    end else begin
      if (arg_we)              arg_q  <= arg_wdata;
      if (cmd_we && cmd_be[0]) cmd_lo <= cmd_wdata[7:0];
    end
  end

  assign launch_req  = cmd_we && cmd_be[1];
  assign launch_word = {cmd_wdata[15:8], cmd_be[0] ? cmd_wdata[7:0] : cmd_lo};

  sdcmd_swreset #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst(rst), .wr(srst_we), .wdata(srst_wdata),
    .bits(srst_bits), .hit(rst_hit), .active(rst_active),
    .clr_cmd(clr_cmd), .clr_dat(clr_dat), .clr_all(clr_all)
  );

  sdcmd_issue_ctl #(.ARG_W(ARG_W)) u_ctl (
    .clk(clk), .rst(rst), .launch_req(launch_req), .launch_word(launch_word),
    .arg_q(arg_q), .rst_hit(rst_hit), .rst_active(rst_active),
    .clr_cmd(clr_cmd), .clr_dat(clr_dat), .ser_done(ser_done), .ser_err(ser_err),
    .busy_end(ser_busy_end), .xfer_done(ser_xfer_done), .start(start),
    .start_f(sf), .start_arg(start_arg), .inh_cmd(inhibit_cmd),
    .inh_dat(inhibit_dat), .cmd_cmpl(cmd_complete), .xfer_cmpl(xfer_complete),
    .done_ok(done_ok), .pend_rsp(pend_rsp)
  );

  sdcmd_resp_store #(.WORDS(RESP_WORDS)) u_resp (
    .clk(clk), .rst(rst), .clear(clr_all), .capture(done_ok),
    .kind(pend_rsp), .raw(ser_resp), .words(resp_words)
  );

  assign start_word     = sf.word;
  assign start_index    = sf.index;
  assign start_rsp      = sf.rsp;
  assign start_abort    = sf.abort;
  assign start_data     = sf.data;
  assign start_idx_chk  = sf.idx_chk;
  assign start_crc_chk  = sf.crc_chk;
  assign start_dat_line = sf.dat_line;
  assign abort_cmd      = srst_bits[0] || srst_bits[1];
  assign abort_dat      = srst_bits[0] || srst_bits[2];

  // R11: abort outputs track the reset register
  a_r11_abort_flags: assert property (@(posedge clk) disable iff (rst)
    (srst_we && srst_wdata[0]) |=> (abort_cmd && abort_dat));

endmodule

// File: tb/sdcmd_issue_bench.sv
module sdcmd_issue_bench;
  localparam int RSTC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         arg_we = 0, cmd_we = 0, srst_we = 0;
  logic [31:0]  arg_wdata = 0;
  logic [1:0]   cmd_be = 0;
  logic [15:0]  cmd_wdata = 0;
  logic [2:0]   srst_wdata = 0;
  logic         ser_done = 0, ser_err = 0, ser_busy_end = 0, ser_xfer_done = 0;
  logic [127:0] ser_resp = 0;

  logic         start, start_abort, start_data, start_idx_chk, start_crc_chk, start_dat_line;
  logic [15:0]  start_word;
  logic [5:0]   start_index;
  logic [1:0]   start_rsp;
  logic [31:0]  start_arg;
  logic         inhibit_cmd, inhibit_dat, cmd_complete, xfer_complete, abort_cmd, abort_dat;
  logic [127:0] resp_words;
  logic [2:0]   srst_bits;

  sdcmd_issue #(.ARG_W(32), .RST_CYCLES(RSTC)) u_sdcmd_issue (
    .clk(clk), .rst(rst), .arg_we(arg_we), .arg_wdata(arg_wdata),
    .cmd_we(cmd_we), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
    .srst_we(srst_we), .srst_wdata(srst_wdata), .ser_done(ser_done),
    .ser_err(ser_err), .ser_busy_end(ser_busy_end), .ser_xfer_done(ser_xfer_done),
    .ser_resp(ser_resp), .start(start), .start_word(start_word),
    .start_index(start_index), .start_rsp(start_rsp), .start_abort(start_abort),
    .start_data(start_data), .start_idx_chk(start_idx_chk),
    .start_crc_chk(start_crc_chk), .start_dat_line(start_dat_line),
    .start_arg(start_arg), .inhibit_cmd(inhibit_cmd), .inhibit_dat(inhibit_dat),
    .cmd_complete(cmd_complete), .xfer_complete(xfer_complete),
    .resp_words(resp_words), .srst_bits(srst_bits), .abort_cmd(abort_cmd),
    .abort_dat(abort_dat)
  );

  int checks = 0, failures = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_ic, m_id, m_bybusy, m_start, m_cc, m_xc;
  bit  [7:0]   m_lo;
  bit  [31:0]  m_arg, m_sarg;
  bit  [15:0]  m_sword;
  bit  [1:0]   m_kind;
  bit  [127:0] m_resp;
  bit  [2:0]   m_srst;
  int          m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_ic = 0; m_id = 0; m_bybusy = 0; m_start = 0; m_cc = 0; m_xc = 0;
      m_lo = 0; m_arg = 0; m_sarg = 0; m_sword = 0; m_kind = 0; m_resp = 0;
      m_srst = 0; m_cnt = 0;
    end else begin
      bit hit, quiet, nd, go, dn, er, be, xd;
      bit [15:0] w;
      hit   = srst_we && (srst_wdata != 0);
      quiet = !hit && (m_srst == 0);
      w     = {cmd_wdata[15:8], cmd_be[0] ? cmd_wdata[7:0] : m_lo};
      nd    = w[5] || (w[1:0] == 2'd3);
      go    = cmd_we && cmd_be[1] && quiet && !m_ic && !(nd && m_id);
      dn    = ser_done && m_ic && quiet;
      er    = ser_err && m_ic && quiet;
      be    = ser_busy_end && m_id && m_bybusy && quiet;
      xd    = ser_xfer_done && m_id && !m_bybusy && quiet;
      // response first: it uses the pending kind
      if (hit && srst_wdata[0]) m_resp = 0;
      else if (dn && m_kind == 2'd1) m_resp = {8'h00, ser_resp[127:8]};
      else if (dn && m_kind >= 2'd2) m_resp[31:0] = ser_resp[31:0];
      m_start = go; m_cc = dn; m_xc = be || xd;
      if (go) begin m_sword = w; m_sarg = m_arg; m_kind = w[1:0]; end
      if (hit && (srst_wdata[0] || srst_wdata[1])) m_ic = 0;
      else if (go) m_ic = 1;
      else if (dn || er) m_ic = 0;
      if (hit && (srst_wdata[0] || srst_wdata[2])) m_id = 0;
      else if (go && nd) begin m_id = 1; m_bybusy = (w[1:0] == 2'd3); end
      else if (be || xd) m_id = 0;
      if (hit) begin m_srst = m_srst | srst_wdata; m_cnt = RSTC; end
      else if (m_srst != 0) begin
        m_cnt--;
        if (m_cnt == 0) m_srst = 0;
      end
      if (arg_we) m_arg = arg_wdata;
      if (cmd_we && cmd_be[0]) m_lo = cmd_wdata[7:0];
    end
  end

  // Compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done_flag) begin
      chk(start == m_start, "R2 R3 start", 128'(start), 128'(m_start));
      if (m_start) begin
        chk(start_word == m_sword, "R2 word", 128'(start_word), 128'(m_sword));
        chk(start_arg == m_sarg, "R2 arg", 128'(start_arg), 128'(m_sarg));
        chk({start_index, start_abort, start_data, start_idx_chk, start_crc_chk,
             start_rsp, start_dat_line} ==
            {m_sword[13:8], m_sword[7:6] == 2'd3, m_sword[5], m_sword[4], m_sword[3],
             m_sword[1:0], m_sword[5] || m_sword[1:0] == 2'd3},
            "R2 fields", 128'(start_index), 128'(m_sword[13:8]));
      end
      chk(inhibit_cmd == m_ic, "R4 inhibit_cmd", 128'(inhibit_cmd), 128'(m_ic));
      chk(inhibit_dat == m_id, "R5 R7 inhibit_dat", 128'(inhibit_dat), 128'(m_id));
      chk(cmd_complete == m_cc, "R6 cmd_complete", 128'(cmd_complete), 128'(m_cc));
      chk(xfer_complete == m_xc, "R7 xfer_complete", 128'(xfer_complete), 128'(m_xc));
      chk(resp_words == m_resp, "R8 R9 resp", resp_words, m_resp);
      chk(srst_bits == m_srst, "R10 srst_bits", 128'(srst_bits), 128'(m_srst));
      chk({abort_cmd, abort_dat} == {m_srst[0] | m_srst[1], m_srst[0] | m_srst[2]},
          "R11 abort", 128'({abort_cmd, abort_dat}),
          128'({m_srst[0] | m_srst[1], m_srst[0] | m_srst[2]}));
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      arg_we = 0; cmd_we = 0; cmd_be = 0; srst_we = 0; srst_wdata = 0;
      ser_done = 0; ser_err = 0; ser_busy_end = 0; ser_xfer_done = 0;
    end
  endtask

  task automatic issue(input logic [15:0] w);
    cmd_we = 1; cmd_be = 2'b11; cmd_wdata = w;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 0;
    tick();
    // R1 reset state
    chk({inhibit_cmd, inhibit_dat, start, cmd_complete, xfer_complete, srst_bits,
         abort_cmd, abort_dat} == 0 && resp_words == 0, "R1 reset state",
        128'({inhibit_cmd, inhibit_dat, start, srst_bits}), 128'(0));

    // R2: argument, low byte alone, then upper byte launches, short response
    arg_we = 1; arg_wdata = 32'h1234_5678; tick();
    cmd_we = 1; cmd_be = 2'b01; cmd_wdata = 16'h00_1A; tick();
    chk(start == 1'b0, "R2 low byte no launch", 128'(start), 128'(0));
    cmd_we = 1; cmd_be = 2'b10; cmd_wdata = 16'h1100; tick();
    chk(start == 1'b1 && start_word == 16'h111A && start_arg == 32'h1234_5678,
        "R2 launch", 128'({start_word, start_arg}), 128'({16'h111A, 32'h1234_5678}));
    tick(2);
    ser_done = 1; ser_resp = {32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'h0000_0900};
    tick(2);

    // R7: busy command; data flag held while other traffic occurs
    arg_we = 1; arg_wdata = 32'h0000_00FF; tick();
    issue(16'h0C1B); tick(2);
    ser_done = 1; ser_resp = 128'h5555; tick(2);
    issue(16'h0D1A); tick();
    chk(start == 1'b1, "R3 short cmd allowed while dat held", 128'(start), 128'(1));
    tick();
    ser_done = 1; tick();
    issue(16'h1132); tick();
    chk(start == 1'b0, "R3 data cmd refused while dat held", 128'(start), 128'(0));
    ser_xfer_done = 1; tick();
    chk(inhibit_dat == 1'b1, "R7 xfer_done ignored for busy", 128'(inhibit_dat), 128'(1));
    ser_busy_end = 1; tick(2);

    // Data command: busy_end ignored, xfer_done releases
    issue(16'h1132); tick(2);
    ser_done = 1; tick();
    ser_busy_end = 1; tick(2);
    ser_xfer_done = 1; tick(2);

    // R9: long response with CRC dropped
    issue(16'h0209); tick(2);
    ser_done = 1;
    ser_resp = 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10; tick();
    chk(resp_words == 128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F, "R9 long resp",
        resp_words, 128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F);
    tick();

    // R3/R6: launch while command flag held, then error release
    issue(16'h1A1A); tick();
    issue(16'h1B1A); tick();
    chk(start == 1'b0, "R3 launch refused while cmd held", 128'(start), 128'(0));
    ser_err = 1; tick(2);
    ser_done = 1; tick(2);   // stray done: ignored (R6)

    // R8: no-response command leaves response untouched; abort type
    issue(16'h00C0); tick(2);
    ser_done = 1; ser_resp = ~128'h0; tick(2);

    // R11: launch dropped by command reset in the same cycle
    issue(16'h0502); srst_we = 1; srst_wdata = 3'b010; tick();
    chk(start == 1'b0 && srst_bits == 3'b010, "R11 launch dropped by reset",
        128'({start, srst_bits}), 128'(3'b010));
    issue(16'h0502); tick(RSTC + 1);   // R10 ignored while active
    issue(16'h0D1B); tick(2);
    ser_done = 1; ser_resp = 128'h77; tick(2);
    srst_we = 1; srst_wdata = 3'b100; tick();
    ser_busy_end = 1; tick(RSTC + 1);
    // done during active reset ignored, then bit0 clears responses
    issue(16'h0702); tick(2);
    srst_we = 1; srst_wdata = 3'b001; ser_done = 1; ser_resp = 128'h99; tick();
    chk(resp_words == 0 && inhibit_cmd == 0, "R11 reset all clears",
        resp_words, 128'(0));
    ser_done = 1; tick(RSTC + 2);
    issue(16'h0702); tick(2);
    ser_done = 1; ser_resp = 128'h4242; tick(3);

    finish_run();
  end

endmodule